// File: doc/BRIEF.md
# Triple-Echo Message Validator with Interrupts

This block watches three independent loop channels. Each channel delivers a control-channel message once per frame period, marked by a one-cycle valid strobe. A message is trusted only when the same content arrives on three consecutive strobes. When that happens, the loop's integrated message register is loaded and a compare-detected status bit is raised. Each loop also has a level input that says it is ready to receive indicator data. That input feeds its own status bit.

Software reaches the block through a small synchronous register port. The enable register is at 0x1F and the status register is at 0x20. Status bits clear when 1 is written to them, but a bit whose source is active in the same cycle stays set. Each loop's compare enable bit also selects the message that loop presents on its receive output: the validated message when the bit is 1, and the raw message from the latest frame when it is 0. The interrupt output is the OR of every status bit masked by its enable bit.

Each loop runs a four-state machine:
- `ST_IDLE`: no message seen yet.
- `ST_ONCE`: one reception of the candidate message.
- `ST_TWICE`: two identical receptions in a row.
- `ST_LOCKED`: three or more identical receptions in a row.

Its transitions are:
- First: `ST_IDLE` to `ST_ONCE` on any strobe.
- Echo: `ST_ONCE` to `ST_TWICE` on a matching strobe.
- Lock: `ST_TWICE` to `ST_LOCKED` on a matching strobe.
- Hold: `ST_LOCKED` to `ST_LOCKED` on a matching strobe.
- Restart: any of `ST_ONCE`, `ST_TWICE` or `ST_LOCKED` to `ST_ONCE` on a differing strobe.

Top module: `echo3_validator`

## Requirements
- R1: After reset, both registers read 0x00, `irq` is 0 and every loop's receive output is 0.
- R2: The compare-detected status bit of loop n (status bit n-1, so loop 1 is bit 0) sets in the clock edge of the third consecutive strobe carrying identical content, and not before.
- R3: The integrated message of a loop changes only on a Lock transition, where it takes the locking message. The raw message takes every strobed message.
- R4: A strobe whose content differs from the previous one restarts the count at one. That strobe counts as the first of a new run.
- R5: A Lock whose message equals the content already held in the integrated register does not set the compare-detected status bit.
- R6: Writing to address 0x20 clears each status bit written with 1 and leaves bits written with 0 untouched. A bit whose source is active in the write cycle stays set.
- R7: The enable register at 0x1F is read/write on bits 5:0. Bits 7:6 of both registers always read 0, and any other address reads 0x00.
- R8: With enable bit n-1 set to 1, loop n's receive output shows its integrated message. With the bit at 0, it shows the raw message.
- R9: The ready-to-receive status bit of loop n (status bit n+2, so loop 1 is bit 3) sets while `ind_rdy[n-1]` is high and is sticky after the input drops.
- R10: `irq` is high exactly when some status bit and its enable bit, at the same position, are both 1.
- R11: Strobes on one loop never change another loop's status bits or receive output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_vld | input | 3 | One-cycle message strobe per loop (bit 0 = loop 1) |
| msg_in | input | 3*MSG_W | Message per loop, loop 1 in the lowest slice |
| ind_rdy | input | 3 | Ready-to-receive indicator source per loop |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| rx_msg | output | 3*MSG_W | Receive message per loop, chosen by the compare enable |
| irq | output | 1 | Level, active-high interrupt |

## Verification
The bench sweeps every two-symbol message sequence of length five on each loop in turn and compares against a run-length model. Each sweep reads the status register and both receive-output views after every strobe. A validator that set its status bit after two echoes, or that failed to restart the count on a differing message, would disagree with the model on sequences such as A A B B B. A design that re-flagged a repeat of the integrated message would be caught by the A A A B A A A pattern. A clear that beats a still-active indicator source would drop bit 3 while `ind_rdy` is held high.

// File: rtl/echo_pkg.sv
package echo_pkg;
    localparam int NUM_LOOPS = 3;
    localparam int REG_W = 8;
    localparam int STAT_W = 2 * NUM_LOOPS;
    localparam logic [7:0] ADDR_ENABLE = 8'h1F;
    localparam logic [7:0] ADDR_STATUS = 8'h20;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ONCE,
        ST_TWICE,
        ST_LOCKED
    } echo_state_t;
endpackage

// File: rtl/echo_loop.sv
module echo_loop
    import echo_pkg::*;
#(
    parameter int MSG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld,
    input  logic [MSG_W-1:0] msg,
    input  logic             cmp_en,
    output logic             hit,
    output logic [MSG_W-1:0] rx_msg
);
    echo_state_t      state_q, state_d;
    logic [MSG_W-1:0] last_q, raw_q, integ_q;
    logic             have_q;
    logic             match, fresh, lock_now;

    assign match = (msg == last_q);
    assign fresh = !have_q || (msg != integ_q);

    // next-state process
    always_comb begin
        state_d = state_q;
        if (vld) begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_ONCE;
                ST_ONCE:   state_d = match ? ST_TWICE : ST_ONCE;
                ST_TWICE:  state_d = match ? ST_LOCKED : ST_ONCE;
                ST_LOCKED: state_d = match ? ST_LOCKED : ST_ONCE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // output process
    always_comb begin
        lock_now = vld && (state_q == ST_TWICE) && match;
        hit      = lock_now && fresh;
        rx_msg   = cmp_en ? integ_q : raw_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q  <= '0;
            raw_q   <= '0;
            integ_q <= '0;
            have_q  <= 1'b0;
        end else begin
            if (vld) begin
                last_q <= msg;
                raw_q  <= msg;
            end
            if (lock_now) begin
                integ_q <= msg;
                have_q  <= 1'b1;
            end
        end
    end

    AST_HIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (state_q == ST_LOCKED)); // R2
    AST_INTEG_ON_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (integ_q != $past(integ_q)) |-> $past(vld && state_q == ST_TWICE)); // R3
    AST_RAW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> (raw_q == $past(msg))); // R3
endmodule

// File: rtl/echo_regs.sv
module echo_regs
    import echo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_LOOPS-1:0] hit,
    input  logic [NUM_LOOPS-1:0] ind_rdy,
    input  logic [7:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [NUM_LOOPS-1:0] cmp_en,
    output logic              irq
);
    logic [STAT_W-1:0] en_q, stat_q, stat_d, src, clr;
    logic              wr_en_reg, wr_st_reg;

    assign src       = {ind_rdy, hit};
    assign wr_en_reg = reg_wr && (reg_addr == ADDR_ENABLE);
    assign wr_st_reg = reg_wr && (reg_addr == ADDR_STATUS);
    assign clr       = wr_st_reg ? reg_wdata[STAT_W-1:0] : '0;

    always_comb begin
        stat_d = (stat_q & ~clr) | src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            stat_q <= '0;
        end else begin
            if (wr_en_reg) en_q <= reg_wdata[STAT_W-1:0];
            stat_q <= stat_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_ENABLE)      reg_rdata[STAT_W-1:0] = en_q;
        else if (reg_addr == ADDR_STATUS) reg_rdata[STAT_W-1:0] = stat_q;
        cmp_en = en_q[NUM_LOOPS-1:0];
        irq    = |(en_q & stat_q);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (src != '0) |=> ((stat_q & $past(src)) == $past(src))); // R6
    AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_q) & ~stat_q) != '0) |-> $past(wr_st_reg)); // R6
endmodule

// File: rtl/echo3_validator.sv
module echo3_validator
    import echo_pkg::*;
#(
    parameter int MSG_W = 13
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LOOPS-1:0]       msg_vld,
    input  logic [NUM_LOOPS*MSG_W-1:0] msg_in,
    input  logic [NUM_LOOPS-1:0]       ind_rdy,
    input  logic [7:0]                 reg_addr,
    input  logic                       reg_wr,
    input  logic [REG_W-1:0]           reg_wdata,
    output logic [REG_W-1:0]           reg_rdata,
    output logic [NUM_LOOPS*MSG_W-1:0] rx_msg,
    output logic                       irq
);
    logic [NUM_LOOPS-1:0] hit, cmp_en;

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
        echo_loop #(.MSG_W(MSG_W)) u_loop (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld    (msg_vld[g]),
            .msg    (msg_in[g*MSG_W +: MSG_W]),
            .cmp_en (cmp_en[g]),
            .hit    (hit[g]),
            .rx_msg (rx_msg[g*MSG_W +: MSG_W])
        );
    end

    echo_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .ind_rdy   (ind_rdy),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cmp_en    (cmp_en),
        .irq       (irq)
    );

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:6] == 2'b00); // R7
endmodule

// File: tb/echo3_validator_test.sv
module echo3_validator_test;
    localparam int W = 13;
    localparam int CLK_NS = 10;

    logic           clk = 0;
    logic           rst_n = 0;
    logic [2:0]     msg_vld = 0;
    logic [3*W-1:0] msg_in = 0;
    logic [2:0]     ind_rdy = 0;
    logic [7:0]     reg_addr = 0;
    logic           reg_wr = 0;
    logic [7:0]     reg_wdata = 0;
    logic [7:0]     reg_rdata;
    logic [3*W-1:0] rx_msg;
    logic           irq;

    int errors = 0;
    int checks = 0;

    // model state for one loop
    logic [W-1:0] m_last, m_raw, m_integ;
    logic         m_have;
    int           m_cnt;
    logic         m_stat;

    echo3_validator #(.MSG_W(W)) uut (.*);

    always #(CLK_NS/2) clk = ~clk;

    initial begin
        #(CLK_NS * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        msg_vld = 0;
        ind_rdy = 0;
        reg_wr = 0;
        @(negedge clk);
        rst_n = 1;
        m_last = 0; m_raw = 0; m_integ = 0; m_have = 0; m_cnt = 0; m_stat = 0;
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(posedge clk);
        #1 reg_wr = 0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send(input int lp, input logic [W-1:0] m);
        @(negedge clk);
        msg_in[lp*W +: W] = m;
        msg_vld[lp] = 1;
        @(posedge clk);
        #1 msg_vld = 0;
        m_raw = m;
        if (m_cnt == 0 || m != m_last) begin
            m_cnt = 1;
            m_last = m;
        end else begin
            m_cnt++;
        end
        if (m_cnt == 3) begin
            if (!m_have || m != m_integ) m_stat = 1;
            m_integ = m;
            m_have = 1;
        end
    endtask

    initial begin
        logic [7:0] rd;
        do_reset();
        // R1 reset state
        reg_read(8'h1F, rd); check("R1 enable", rd, 8'h00);
        reg_read(8'h20, rd); check("R1 status", rd, 8'h00);
        check("R1 irq", irq, 0);
        check("R1 rx", rx_msg, 0);

        // R2 R3 R4 R8 R11 sweep over all 2-symbol length-5 sequences
        for (int lp = 0; lp < 3; lp++) begin
            for (int s = 0; s < 32; s++) begin
                do_reset();
                for (int k = 0; k < 5; k++) begin
                    logic [W-1:0] a, b;
                    a = W'(13'h0A5 + lp);
                    b = W'(13'h1F00 ^ lp);
                    send(lp, ((s >> k) & 1) ? b : a);
                    reg_read(8'h20, rd);
                    check("R2 R4 status", rd, 8'(m_stat) << lp);
                    check("R8 raw view", rx_msg[lp*W +: W], m_raw);
                    check("R11 other loops", rx_msg & ~({W{1'b1}} << (lp*W)) & ~(({W{1'b1}} << (lp*W)) & ~({3*W{1'b1}} << ((lp+1)*W))), 0);
                    reg_write(8'h1F, 8'(1) << lp);
                    #1 check("R3 integ view", rx_msg[lp*W +: W], m_integ);
                    check("R10 irq", irq, m_stat);
                    reg_write(8'h1F, 8'h00);
                    if (m_stat) begin
                        reg_write(8'h20, 8'(1) << lp);
                        m_stat = 0;
                    end
                end
            end
        end

        // R5 repeat of the integrated message does not re-flag
        do_reset();
        send(1, 13'h111); send(1, 13'h111); send(1, 13'h111);
        reg_read(8'h20, rd); check("R2 lock loop2", rd, 8'h02);
        reg_write(8'h20, 8'h02);
        send(1, 13'h222);
        send(1, 13'h111); send(1, 13'h111); send(1, 13'h111);
        reg_read(8'h20, rd); check("R5 no re-flag", rd, 8'h00);
        send(1, 13'h222); send(1, 13'h222); send(1, 13'h222);
        reg_read(8'h20, rd); check("R5 new message flags", rd, 8'h02);

        // R9 R6 indicator source held across clear
        do_reset();
        @(negedge clk) ind_rdy = 3'b001;
        @(posedge clk); #1;
        reg_read(8'h20, rd); check("R9 indicator set", rd, 8'h08);
        reg_write(8'h20, 8'h08);
        reg_read(8'h20, rd); check("R6 held source", rd, 8'h08);
        @(negedge clk) ind_rdy = 3'b000;
        reg_read(8'h20, rd); check("R9 sticky", rd, 8'h08);
        reg_write(8'h20, 8'h00);
        reg_read(8'h20, rd); check("R6 zero write", rd, 8'h08);
        check("R10 masked", irq, 0);
        reg_write(8'h1F, 8'h08);
        #1 check("R10 enabled", irq, 1);
        reg_write(8'h20, 8'hFF);
        reg_read(8'h20, rd); check("R6 clear", rd, 8'h00);
        check("R10 cleared", irq, 0);

        // R7 register layout
        reg_write(8'h1F, 8'hFF);
        reg_read(8'h1F, rd); check("R7 enable rw", rd, 8'h3F);
        reg_read(8'h20, rd); check("R7 status unset by write", rd, 8'h00);
        reg_read(8'h21, rd); check("R7 other addr", rd, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule